// File: doc/BRIEF.md
# Transceiver Analog-Setting Reconfiguration Sequencer

This block is a request sequencer for the analog tuning values of a group of transceiver channels. Each channel holds six settings: a pre-cursor tap, a first post-cursor tap, a second post-cursor tap, the output swing, the equalizer setting and the equalizer DC gain. A requester presents a one-cycle request that selects a setting, read or write, a target channel and, for writes, a value. The block then raises `busy` for a window whose length depends on the setting, on the direction, and on whether one channel or every channel is addressed.

The analog programming path is not modelled. Each access is a timed update of an internal table of current values. A write changes the table only when its busy window closes. A read returns the stored value together with a one-cycle valid pulse once busy has dropped.

In broadcast mode the channel address is ignored. A broadcast write updates every channel, and its busy window is the per-channel time multiplied by the channel count. A broadcast read returns channel 0's value.

Top module: `xcvr_tune_seq`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low, `rd_data` is zero and every stored setting of every channel is zero.
- R2: An accepted write to setting code 1 (first post-tap), 3 (output swing), 4 (equalizer) or 5 (DC gain) to a single channel keeps `busy` high for exactly WR_SHORT (default 260) cycles.
- R3: An accepted write to setting code 0 (pre-tap) or 2 (second post-tap) to a single channel keeps `busy` high for exactly WR_LONG (default 520) cycles.
- R4: An accepted read keeps `busy` high for RD_SHORT (default 130) cycles for codes 1, 3, 4 and 5, and for RD_LONG (default 260) cycles for codes 0 and 2.
- R5: `rd_valid` is a single-cycle pulse. It is high in the first cycle that `busy` is low after a read, and it is never raised after a write.
- R6: `rd_data` takes the addressed setting's stored value in the `rd_valid` cycle and keeps it until the next read completes.
- R7: With `req_bcast` low, a write changes only the setting on channel `req_ch`.
- R8: With `req_bcast` high, a write ignores `req_ch`, updates that setting on all NUM_CH channels, and keeps `busy` high for NUM_CH times the single-channel write time.
- R9: With `req_bcast` high, a read ignores `req_ch`, returns channel 0's value, and uses the single-channel read time.
- R10: A request presented while `busy` is high is ignored, and a write's value becomes readable only after its busy window ends.
- R11: Setting codes 6 and 7 are rejected: `busy` stays low and no stored value changes.
- R12: A request is accepted on a rising edge where `req_valid` is high, `busy` is low and the code is legal. `busy` is high in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Setting code 0..5; 6 and 7 illegal |
| req_bcast | input | 1 | 1 = all channels, address ignored |
| req_ch | input | CH_W | Target channel in addressed mode |
| req_data | input | VAL_W | Write value |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | VAL_W | Last read value, held |

## Verification
The assertions check on every cycle that `rd_valid` is a lone pulse that follows a falling `busy`, and that `rd_data` moves only with that pulse. They also check that a legal idle request starts `busy` on the next cycle, and that an illegal code leaves it low. Only the bench scenarios can show the exact window lengths for each code, direction and mode, which channels a write reaches, the channel-0 source of broadcast reads, and that a request made during `busy` leaves the table alone. A behavioural model compares `busy`, `rd_valid` and `rd_data` against the design on every clock.

// File: rtl/tune_pkg.sv
package tune_pkg;
    localparam int NSEL = 6;

    typedef enum logic [2:0] {
        SEL_PRE   = 3'd0,
        SEL_POST1 = 3'd1,
        SEL_POST2 = 3'd2,
        SEL_SWING = 3'd3,
        SEL_EQ    = 3'd4,
        SEL_DCG   = 3'd5
    } sel_e;

    function automatic logic sel_legal(input logic [2:0] s);
        return s < 3'(NSEL);
    endfunction

    function automatic logic sel_long(input logic [2:0] s);
        return (s == SEL_PRE) || (s == SEL_POST2);
    endfunction
endpackage

// File: rtl/tune_dur_sel.sv
module tune_dur_sel #(
    parameter int NUM_CH   = 4,
    parameter int RD_SHORT = 130,
    parameter int RD_LONG  = 260,
    parameter int WR_SHORT = 260,
    parameter int WR_LONG  = 520,
    parameter int CNT_W    = 12
) (
    input  logic [2:0]       sel,
    input  logic             wr,
    input  logic             bcast,
    output logic [CNT_W-1:0] dur_m1
);
    import tune_pkg::*;

    int base;
    int total;

    always_comb begin
        if (wr) base = sel_long(sel) ? WR_LONG : WR_SHORT;
        else    base = sel_long(sel) ? RD_LONG : RD_SHORT;
        total  = (wr && bcast) ? base * NUM_CH : base;
        dur_m1 = CNT_W'(total - 1);
    end
endmodule

// File: rtl/tune_regfile.sv
module tune_regfile #(
    parameter int NUM_CH = 4,
    parameter int VAL_W  = 5,
    parameter int CH_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             bcast,
    input  logic [CH_W-1:0]  ch,
    input  logic [2:0]       sel,
    input  logic [VAL_W-1:0] wdata,
    output logic [VAL_W-1:0] rdata
);
    import tune_pkg::*;

    logic [VAL_W-1:0] mem_q [NUM_CH][NSEL];
    logic [VAL_W-1:0] mem_d [NUM_CH][NSEL];

    always_comb begin
        mem_d = mem_q;
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int s = 0; s < NSEL; s++) begin
                if (we && (bcast || ch == CH_W'(c)) && sel == 3'(s))
                    mem_d[c][s] = wdata;
                if (ch == CH_W'(c) && sel == 3'(s))
                    rdata = mem_q[c][s];
            end
        end
    end

    generate
        for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
            always_ff @(posedge clk) begin
                for (int s = 0; s < NSEL; s++) begin
                    if (!rst_n) mem_q[gc][s] <= '0;
                    else        mem_q[gc][s] <= mem_d[gc][s];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/xcvr_tune_seq.sv
module xcvr_tune_seq #(
    parameter int NUM_CH   = 4,
    parameter int VAL_W    = 5,
    parameter int RD_SHORT = 130,
    parameter int RD_LONG  = 260,
    parameter int WR_SHORT = 260,
    parameter int WR_LONG  = 520,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CNT_W   = $clog2(WR_LONG * NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [2:0]       req_sel,
    input  logic             req_bcast,
    input  logic [CH_W-1:0]  req_ch,
    input  logic [VAL_W-1:0] req_data,
    output logic             busy,
    output logic             rd_valid,
    output logic [VAL_W-1:0] rd_data
);
    import tune_pkg::*;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             wr;
        logic             bcast;
        logic [CH_W-1:0]  ch;
        logic [2:0]       sel;
        logic [VAL_W-1:0] data;
        logic             rdv;
        logic [VAL_W-1:0] rdata;
    } st_t;

    st_t st_q, st_d;
    logic [CNT_W-1:0] dur_m1;
    logic             rf_we;
    logic [VAL_W-1:0] rf_rdata;

    tune_dur_sel #(
        .NUM_CH(NUM_CH), .RD_SHORT(RD_SHORT), .RD_LONG(RD_LONG),
        .WR_SHORT(WR_SHORT), .WR_LONG(WR_LONG), .CNT_W(CNT_W)
    ) u_dur (
        .sel(req_sel), .wr(req_write), .bcast(req_bcast), .dur_m1(dur_m1)
    );

    tune_regfile #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .CH_W(CH_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .bcast(st_q.bcast),
        .ch(st_q.ch), .sel(st_q.sel), .wdata(st_q.data), .rdata(rf_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdv = 1'b0;
        rf_we    = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                if (st_q.wr) begin
                    rf_we = 1'b1;
                end else begin
                    st_d.rdv   = 1'b1;
                    st_d.rdata = rf_rdata;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (req_valid && sel_legal(req_sel)) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = dur_m1;
            st_d.wr    = req_write;
            st_d.bcast = req_bcast;
            st_d.ch    = req_bcast ? '0 : req_ch;
            st_d.sel   = req_sel;
            st_d.data  = req_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign rd_valid = st_q.rdv;
    assign rd_data  = st_q.rdata;

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r5_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!busy && $past(busy)));
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> rd_valid);
    a_r12_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && sel_legal(req_sel)) |=> busy);
    a_r11_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !sel_legal(req_sel)) |=> !busy);
endmodule

// File: tb/xcvr_tune_seq_bench.sv
`timescale 1ns/1ps
module xcvr_tune_seq_bench;
    localparam int NCH = 4;
    localparam int VW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_bcast = 1'b0;
    logic [2:0]    req_sel = '0;
    logic [1:0]    req_ch = '0;
    logic [VW-1:0] req_data = '0;
    logic          busy, rd_valid;
    logic [VW-1:0] rd_data;

    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    xcvr_tune_seq u_xcvr_tune_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_bcast(req_bcast), .req_ch(req_ch),
        .req_data(req_data), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // behavioural reference model
    int m_rf [NCH][6];
    int m_busy, m_left, m_rdv, m_rdata;
    int p_wr, p_bc, p_ch, p_sel, p_dat;

    function automatic int ref_len(int wr, int sel, int bc);
        int b;
        if (wr != 0) b = (sel == 0 || sel == 2) ? 520 : 260;
        else         b = (sel == 0 || sel == 2) ? 260 : 130;
        return (wr != 0 && bc != 0) ? b * NCH : b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_rf[c, s]) m_rf[c][s] = 0;
            m_busy = 0; m_left = 0; m_rdv = 0; m_rdata = 0;
        end else begin
            m_rdv = 0;
            if (m_busy != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0;
                    if (p_wr != 0) begin
                        for (int c = 0; c < NCH; c++)
                            if (p_bc != 0 || c == p_ch) m_rf[c][p_sel] = p_dat;
                    end else begin
                        m_rdv = 1;
                        m_rdata = m_rf[(p_bc != 0) ? 0 : p_ch][p_sel];
                    end
                end
            end else if (req_valid && req_sel < 3'd6) begin
                m_busy = 1;
                p_wr = int'(req_write); p_bc = int'(req_bcast);
                p_ch = int'(req_ch); p_sel = int'(req_sel); p_dat = int'(req_data);
                m_left = ref_len(p_wr, p_sel, p_bc);
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 model busy", int'(busy), m_busy);
            check("R5 model rd_valid", int'(rd_valid), m_rdv);
            check("R6 model rd_data", int'(rd_data), m_rdata);
        end
    end

    // issue one request and follow it to completion; len 0 = expect rejection
    task automatic op(string tag, bit w, int sel, bit bc, int ch, int dat,
                      int len, int exp_rd);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_sel = 3'(sel); req_bcast = bc;
        req_ch = 2'(ch); req_data = VW'(dat);
        @(negedge clk);
        req_valid = 1'b0;
        if (len == 0) begin
            check({tag, " R11 no busy"}, int'(busy), 0);
            return;
        end
        check({tag, " R12 busy start"}, int'(busy), 1);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check({tag, " busy length"}, n, len);
        check({tag, " R5 rd_valid"}, int'(rd_valid), w ? 0 : 1);
        if (!w) check({tag, " R6 rd_data"}, int'(rd_data), exp_rd);
        @(negedge clk);
        check({tag, " R5 pulse end"}, int'(rd_valid), 0);
        if (!w) check({tag, " R6 hold"}, int'(rd_data), exp_rd);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy reset", int'(busy), 0);
        check("R1 rd_valid reset", int'(rd_valid), 0);
        check("R1 rd_data reset", int'(rd_data), 0);
        op("R1 R4 read zero", 0, 3, 0, 1, 0, 130, 0);
        op("R4 long read zero", 0, 2, 0, 3, 0, 260, 0);
        op("R2 write post1", 1, 1, 0, 2, 5, 260, 0);
        op("R7 read back", 0, 1, 0, 2, 0, 130, 5);
        op("R7 other channel", 0, 1, 0, 1, 0, 130, 0);
        op("R3 write pre", 1, 0, 0, 0, 9, 520, 0);
        op("R4 read pre", 0, 0, 0, 0, 0, 260, 9);
        op("R3 write post2", 1, 2, 0, 3, 3, 520, 0);
        op("R2 write dcg", 1, 5, 0, 1, 7, 260, 0);
        op("R2 read dcg", 0, 5, 0, 1, 0, 130, 7);
        op("R8 bcast write", 1, 4, 1, 1, 10, 260 * NCH, 0);
        op("R8 read ch3", 0, 4, 0, 3, 0, 130, 10);
        op("R8 read ch0", 0, 4, 0, 0, 0, 130, 10);
        op("R9 bcast read", 0, 0, 1, 3, 0, 260, 9);
        op("R11 code6", 1, 6, 0, 0, 21, 0, 0);
        op("R11 code7", 1, 7, 1, 0, 22, 0, 0);
        op("R11 after reject", 0, 0, 0, 0, 0, 260, 9);
        // R10: request during busy is dropped
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = 3'd3; req_bcast = 1'b0;
        req_ch = 2'd2; req_data = 5'd4;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (50) @(negedge clk);
        req_valid = 1'b1; req_data = 5'd17; req_ch = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        op("R10 first write kept", 0, 3, 0, 2, 0, 130, 4);
        op("R10 dropped write", 0, 3, 0, 0, 0, 130, 0);
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule